// File: doc/BRIEF.md
# Escaped-Frame Payload Decoder

This block sits behind a UART receiver. It takes the received byte stream and pulls delimited payload packets out of it. Packets open on a separator byte 0xC0. Two-byte escape pairs in the stream are turned back into the bytes they stand for. Payload bytes leave the block one per cycle, with a valid strobe.

The end of a packet has four possible causes: a raw separator, a decoded byte count, a line-idle strobe from the UART, or a break strobe from the UART. Each of the strobe causes has its own enable. Two optional features can be added to a packet. One is a two-byte length header. The other is a 16-bit CCITT CRC trailer, which the block checks.

When a packet ends, the block pulses an end strobe and gives a 3-bit result code with it:

| Code | Meaning |
|------|---------|
| 0 | no error |
| 1 | escape error |
| 2 | CRC mismatch |
| 3 | truncated packet |

A 3-bit state code and a sticky error cause are also available for status readback. A synchronous soft-reset control returns the decoder to its hunting state.

Top module: `frm_payload_rx`

## Requirements
- R1: After rst_ni is released, the outputs are as follows: state_o=0, pay_vld_o=0, pay_end_o=0, err_cause_o=0. The same holds in every cycle that follows a cycle with soft_rst_i high. A byte offered while soft_rst_i is high produces no output. Every open packet is dropped.
- R2: In hunt state (code 0), all bytes other than 0xC0 are ignored, including 0xDB, and so are idle and break strobes. A 0xC0 opens a packet.
- R3: Inside a packet, 0xDB starts an escape pair. The second byte maps as follows: 0xDC gives 0xC0, 0xDD gives 0xDB, 0xDE gives 0x11, and 0xDF gives 0x13. Each mapping works only while its bit of cfg_esc_en_i is set; bits 0 to 3 go in that order. Other raw bytes pass through unchanged.
- R4: An escape pair has an error when its second byte is not one of the four codes, or when its mapping is disabled. The block then pulses pay_end_o with code 1, emits no further bytes of that packet, and returns to hunt.
- R5: With count end off, a raw 0xC0 ends a non-empty packet. pay_end_o rises one cycle after that 0xC0, and the same 0xC0 opens the next packet. A 0xC0 that arrives before any decoded byte is silent. With no CRC, each payload byte appears on pay_byte_o one cycle after its last input byte.
- R6: With count end on, the packet ends with code 0 once the decoded payload count reaches the target. A raw 0xC0 arriving earlier ends the packet with code 3. An enabled idle or break strobe arriving earlier does the same. If the configured count is zero, the block treats it as one.
- R7: With the header on, the first two decoded bytes are a little-endian length and are never output. In count mode this length is the target. A zero length skips the payload.
- R8: With cfg_idle_end_i set, rx_idle_i ends a non-empty packet, and the result code is worked out as for a separator. The block then returns to hunt. With the enable clear, the strobe has no effect.
- R9: With cfg_brk_end_i set, rx_brk_i ends a non-empty packet in the same way as R8. With the enable clear, the strobe has no effect.
- R10: When cfg_crc_i is set, two trailer bytes follow the payload, most significant byte first. The CRC uses polynomial 0x1021, starts from 0xFFFF and covers the payload. The trailer is never output, and a mismatch gives code 2. In separator mode, output lags by two payload bytes. A packet with fewer than two post-header bytes gives code 3.
- R11: state_o reads as follows: 0 hunt, 1 header, 2 payload, 3 trailer. err_cause_o holds the last non-zero result code.
- R12: When an enabled idle or break strobe arrives in the same cycle as a byte, the packet ends and the byte is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| soft_rst_i | input | 1 | synchronous decoder reset |
| rx_vld_i | input | 1 | received byte valid |
| rx_byte_i | input | 8 | received byte |
| rx_idle_i | input | 1 | UART idle strobe |
| rx_brk_i | input | 1 | UART break strobe |
| cfg_len_end_i | input | 1 | end on byte count |
| cfg_hdr_i | input | 1 | packets carry a length header |
| cfg_crc_i | input | 1 | packets carry a CRC trailer |
| cfg_idle_end_i | input | 1 | idle strobe ends a packet |
| cfg_brk_end_i | input | 1 | break strobe ends a packet |
| cfg_esc_en_i | input | 4 | per-character escape enable |
| cfg_len_i | input | LEN_W | configured payload count |
| pay_vld_o | output | 1 | payload byte valid |
| pay_byte_o | output | 8 | payload byte |
| pay_end_o | output | 1 | end-of-packet strobe |
| pay_err_o | output | 3 | result code, valid with pay_end_o |
| state_o | output | 3 | decoder state code |
| err_cause_o | output | 3 | last non-zero result code |

## Verification
A stuck escape flag would corrupt the next byte and show up one cycle later, either as a wrong output byte or as a code 1 end. A wrong count or a wrong state would move pay_end_o off by a cycle or more, or make trailer bytes leak into the payload. The bench sees both of these at the very next packet boundary. A CRC register that is not reloaded would not show until the end strobe, where it appears as code 2 on a packet that should be clean.

// File: rtl/frm_pkg.sv
`timescale 1ns/1ps
package frm_pkg;
  typedef enum logic [2:0] {
    ST_HUNT = 3'd0,
    ST_HDR  = 3'd1,
    ST_PAY  = 3'd2,
    ST_TRL  = 3'd3
  } frm_st_e;

  localparam logic [7:0] SEP_BYTE = 8'hC0;
  localparam logic [7:0] ESC_BYTE = 8'hDB;
  localparam int unsigned NUM_ESC = 4;
  localparam logic [7:0] ESC_CODE [NUM_ESC] = '{8'hDC, 8'hDD, 8'hDE, 8'hDF};
  localparam logic [7:0] ESC_CHAR [NUM_ESC] = '{8'hC0, 8'hDB, 8'h11, 8'h13};

  localparam logic [2:0] RES_OK    = 3'd0;
  localparam logic [2:0] RES_ESC   = 3'd1;
  localparam logic [2:0] RES_CRC   = 3'd2;
  localparam logic [2:0] RES_TRUNC = 3'd3;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/frm_unesc.sv
`timescale 1ns/1ps
module frm_unesc
  import frm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       act_i,
  input  logic       vld_i,
  input  logic [7:0] byte_i,
  input  logic [NUM_ESC-1:0] map_en_i,
  output logic       dv_o,
  output logic [7:0] db_o,
  output logic       sep_o,
  output logic       bad_o
);
  logic pend_q;
  logic hit, ok;
  logic [7:0] mapped;

  always_comb begin
    hit = 1'b0;
    ok = 1'b0;
    mapped = byte_i;
    for (int k = 0; k < NUM_ESC; k++) begin
      if (byte_i == ESC_CODE[k]) begin
        hit = 1'b1;
        ok = map_en_i[k];
        mapped = ESC_CHAR[k];
      end
    end
  end

  always_comb begin
    dv_o = 1'b0;
    db_o = byte_i;
    sep_o = 1'b0;
    bad_o = 1'b0;
    if (act_i && vld_i) begin
      if (pend_q) begin
        if (hit && ok) begin
          dv_o = 1'b1;
          db_o = mapped;
        end else begin
          bad_o = 1'b1;
        end
      end else if (byte_i == SEP_BYTE) begin
        sep_o = 1'b1;
      end else if (byte_i != ESC_BYTE) begin
        dv_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (!act_i)  pend_q <= 1'b0;
    else if (vld_i)   pend_q <= !pend_q && (byte_i == ESC_BYTE);
  end

  assert_esc_arm_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && vld_i && !pend_q && byte_i == ESC_BYTE) |=> pend_q);
  assert_esc_consume_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && pend_q) |=> !pend_q);
endmodule

// File: rtl/frm_crc.sv
`timescale 1ns/1ps
module frm_crc
  import frm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        feed_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_o,
  output logic [15:0] nxt_o
);
  logic [15:0] crc_q;

  assign nxt_o = crc_step(crc_q, byte_i);
  assign crc_o = crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_INIT;
    else if (clr_i)  crc_q <= CRC_INIT;
    else if (feed_i) crc_q <= nxt_o;
  end

  assert_crc_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !feed_i) |=> $stable(crc_q));
endmodule

// File: rtl/frm_payload_rx.sv
`timescale 1ns/1ps
module frm_payload_rx
  import frm_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             rx_vld_i,
  input  logic [7:0]       rx_byte_i,
  input  logic             rx_idle_i,
  input  logic             rx_brk_i,
  input  logic             cfg_len_end_i,
  input  logic             cfg_hdr_i,
  input  logic             cfg_crc_i,
  input  logic             cfg_idle_end_i,
  input  logic             cfg_brk_end_i,
  input  logic [3:0]       cfg_esc_en_i,
  input  logic [LEN_W-1:0] cfg_len_i,
  output logic             pay_vld_o,
  output logic [7:0]       pay_byte_o,
  output logic             pay_end_o,
  output logic [2:0]       pay_err_o,
  output logic [2:0]       state_o,
  output logic [2:0]       err_cause_o
);
  localparam int unsigned HDR_W = 16;

  frm_st_e st_q, st_d;
  logic hidx_q, hidx_d, any_q, any_d;
  logic [7:0] hlo_q, hlo_d, h0_q, h0_d, h1_q, h1_d, ob_q, ob_d;
  logic [1:0] hn_q, hn_d;
  logic [LEN_W-1:0] tgt_q, tgt_d, cnt_q, cnt_d, cnt_inc, hdr_len;
  logic ov_q, ov_d, end_q, end_d, restart, crc_feed;
  logic [2:0] err_q, err_d, cause_q, fin_err;
  logic act, term, dec_vld, dec_sep, dec_bad;
  logic [7:0] dec_byte;
  logic [15:0] crc_q, crc_nxt;
  logic [HDR_W-1:0] hdr_raw;

  assign act  = (st_q != ST_HUNT);
  assign term = act && ((rx_idle_i && cfg_idle_end_i) || (rx_brk_i && cfg_brk_end_i));

  frm_unesc u_unesc (
    .clk_i, .rst_ni, .act_i(act), .vld_i(rx_vld_i && !term), .byte_i(rx_byte_i),
    .map_en_i(cfg_esc_en_i), .dv_o(dec_vld), .db_o(dec_byte), .sep_o(dec_sep), .bad_o(dec_bad)
  );

  frm_crc u_crc (
    .clk_i, .rst_ni, .clr_i(restart), .feed_i(crc_feed), .byte_i(dec_byte),
    .crc_o(crc_q), .nxt_o(crc_nxt)
  );

  assign cnt_inc = cnt_q + 1'b1;
  assign hdr_raw = {dec_byte, hlo_q};
  assign hdr_len = LEN_W'(hdr_raw);

  // result for a packet closed by separator, idle or break
  always_comb begin
    if (cfg_len_end_i || st_q == ST_HDR) fin_err = RES_TRUNC;
    else if (!cfg_crc_i)                 fin_err = RES_OK;
    else if (hn_q != 2'd2)               fin_err = RES_TRUNC;
    else if (crc_q != 16'h0000)          fin_err = RES_CRC;
    else                                 fin_err = RES_OK;
  end

  always_comb begin
    st_d = st_q; hidx_d = hidx_q; hlo_d = hlo_q; tgt_d = tgt_q; cnt_d = cnt_q;
    any_d = any_q; h0_d = h0_q; h1_d = h1_q; hn_d = hn_q;
    ov_d = 1'b0; ob_d = ob_q; end_d = 1'b0; err_d = RES_OK;
    restart = 1'b0; crc_feed = 1'b0;
    if (!act) begin
      if (rx_vld_i && rx_byte_i == SEP_BYTE) restart = 1'b1;
    end else if (term) begin
      if (any_q) begin end_d = 1'b1; err_d = fin_err; end
      st_d = ST_HUNT;
    end else if (dec_sep) begin
      if (any_q) begin end_d = 1'b1; err_d = fin_err; end
      restart = 1'b1;
    end else if (dec_bad) begin
      end_d = 1'b1; err_d = RES_ESC; st_d = ST_HUNT;
    end else if (dec_vld) begin
      any_d = 1'b1;
      case (st_q)
        ST_HDR: begin
          if (!hidx_q) begin
            hlo_d = dec_byte; hidx_d = 1'b1;
          end else begin
            tgt_d = hdr_len; cnt_d = '0;
            if (cfg_len_end_i && hdr_len == '0) begin
              if (cfg_crc_i) st_d = ST_TRL;
              else begin end_d = 1'b1; st_d = ST_HUNT; end
            end else st_d = ST_PAY;
          end
        end
        ST_PAY: begin
          crc_feed = 1'b1;
          if (cfg_len_end_i) begin
            ov_d = 1'b1; ob_d = dec_byte; cnt_d = cnt_inc;
            if (cnt_inc == tgt_q) begin
              cnt_d = '0;
              if (cfg_crc_i) st_d = ST_TRL;
              else begin end_d = 1'b1; st_d = ST_HUNT; end
            end
          end else if (cfg_crc_i) begin
            // hold two bytes back: they may be the trailer
            h0_d = h1_q; h1_d = dec_byte;
            if (hn_q == 2'd2) begin ov_d = 1'b1; ob_d = h0_q; end
            else hn_d = hn_q + 2'd1;
          end else begin
            ov_d = 1'b1; ob_d = dec_byte;
          end
        end
        ST_TRL: begin
          crc_feed = 1'b1; cnt_d = cnt_inc;
          if (cnt_q[0]) begin
            end_d = 1'b1; st_d = ST_HUNT;
            err_d = (crc_nxt != 16'h0000) ? RES_CRC : RES_OK;
          end
        end
        default: ;
      endcase
    end
    if (restart) begin
      hidx_d = 1'b0; cnt_d = '0; any_d = 1'b0; hn_d = 2'd0;
      tgt_d = (cfg_len_i == '0) ? LEN_W'(1) : cfg_len_i;
      st_d = cfg_hdr_i ? ST_HDR : ST_PAY;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_HUNT; hidx_q <= 1'b0; hlo_q <= '0; tgt_q <= '0; cnt_q <= '0;
      any_q <= 1'b0; h0_q <= '0; h1_q <= '0; hn_q <= '0;
      ov_q <= 1'b0; ob_q <= '0; end_q <= 1'b0; err_q <= RES_OK; cause_q <= RES_OK;
    end else if (soft_rst_i) begin
      st_q <= ST_HUNT; hidx_q <= 1'b0; cnt_q <= '0; any_q <= 1'b0; hn_q <= '0;
      ov_q <= 1'b0; end_q <= 1'b0; err_q <= RES_OK; cause_q <= RES_OK;
    end else begin
      st_q <= st_d; hidx_q <= hidx_d; hlo_q <= hlo_d; tgt_q <= tgt_d; cnt_q <= cnt_d;
      any_q <= any_d; h0_q <= h0_d; h1_q <= h1_d; hn_q <= hn_d;
      ov_q <= ov_d; ob_q <= ob_d; end_q <= end_d; err_q <= err_d;
      if (end_d && err_d != RES_OK) cause_q <= err_d;
    end
  end

  assign pay_vld_o   = ov_q;
  assign pay_byte_o  = ob_q;
  assign pay_end_o   = end_q;
  assign pay_err_o   = err_q;
  assign state_o     = st_q;
  assign err_cause_o = cause_q;

  assert_soft_rst_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(soft_rst_i) |-> (state_o == 3'd0 && !pay_vld_o && !pay_end_o));
  assert_out_only_payload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_vld_o |-> $past(st_q) == ST_PAY);
  assert_single_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_end_o |=> !pay_end_o);
  assert_trailer_mode_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TRL) |-> (cfg_len_end_i && cfg_crc_i));
  assert_cause_tracks_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pay_end_o && pay_err_o != 3'd0) |-> err_cause_o == pay_err_o);
endmodule

// File: tb/frm_payload_rx_test.sv
`timescale 1ns/1ps
module frm_payload_rx_test;
  localparam int LEN_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic soft_rst = 1'b0, rx_vld = 1'b0, rx_idle = 1'b0, rx_brk = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic c_len = 1'b0, c_hdr = 1'b0, c_crc = 1'b0, c_idle = 1'b0, c_brk = 1'b0;
  logic [3:0] c_esc = 4'hF;
  logic [LEN_W-1:0] c_cnt = '0;
  logic pay_vld, pay_end;
  logic [7:0] pay_byte;
  logic [2:0] pay_err, state, cause;

  int checks = 0, fails = 0;
  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];
  int end_q[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  frm_payload_rx #(.LEN_W(LEN_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .rx_vld_i(rx_vld), .rx_byte_i(rx_byte),
    .rx_idle_i(rx_idle), .rx_brk_i(rx_brk), .cfg_len_end_i(c_len), .cfg_hdr_i(c_hdr),
    .cfg_crc_i(c_crc), .cfg_idle_end_i(c_idle), .cfg_brk_end_i(c_brk), .cfg_esc_en_i(c_esc),
    .cfg_len_i(c_cnt), .pay_vld_o(pay_vld), .pay_byte_o(pay_byte), .pay_end_o(pay_end),
    .pay_err_o(pay_err), .state_o(state), .err_cause_o(cause)
  );

  always @(negedge clk) if (rst_n) begin
    if (pay_vld) got_q.push_back(pay_byte);
    if (pay_end) end_q.push_back(int'(pay_err));
  end

  function automatic logic [15:0] crc_of(input logic [7:0] d[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (d[i]) for (int b = 7; b >= 0; b--) begin
      if (c[15] ^ d[i][b]) c = {c[14:0], 1'b0} ^ 16'h1021;
      else c = {c[14:0], 1'b0};
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic send(input logic [7:0] b, input bit idl = 1'b0, input bit brk = 1'b0);
    rx_vld = 1'b1; rx_byte = b; rx_idle = idl; rx_brk = brk;
    @(negedge clk);
    rx_vld = 1'b0; rx_idle = 1'b0; rx_brk = 1'b0;
  endtask

  task automatic strobe(input bit idl, input bit brk);
    rx_idle = idl; rx_brk = brk;
    @(negedge clk);
    rx_idle = 1'b0; rx_brk = 1'b0;
  endtask

  task automatic send_enc(input logic [7:0] b, input bit e11, input bit e13);
    if (b == 8'hC0) begin send(8'hDB); send(8'hDC); end
    else if (b == 8'hDB) begin send(8'hDB); send(8'hDD); end
    else if (b == 8'h11 && e11) begin send(8'hDB); send(8'hDE); end
    else if (b == 8'h13 && e13) begin send(8'hDB); send(8'hDF); end
    else send(b);
  endtask

  task automatic setup(input bit l, input bit h, input bit cr, input bit idl, input bit brk,
                       input logic [3:0] esc, input logic [LEN_W-1:0] cnt);
    soft_rst = 1'b1;
    c_len = l; c_hdr = h; c_crc = cr; c_idle = idl; c_brk = brk; c_esc = esc; c_cnt = cnt;
    @(negedge clk);
    soft_rst = 1'b0;
    @(negedge clk);
    got_q.delete(); end_q.delete(); exp_q.delete();
  endtask

  task automatic expect_pkt(input string req, input int exp_err, input int n_end);
    int bad_at;
    repeat (3) @(negedge clk);
    check(got_q.size() == exp_q.size(), {req, " byte count"}, got_q.size(), exp_q.size());
    bad_at = -1;
    if (got_q.size() == exp_q.size())
      foreach (exp_q[i]) if (bad_at < 0 && got_q[i] != exp_q[i]) bad_at = i;
    if (bad_at >= 0) check(1'b0, {req, " byte value"}, got_q[bad_at], exp_q[bad_at]);
    check(end_q.size() == n_end, {req, " end count"}, end_q.size(), n_end);
    if (n_end > 0 && end_q.size() > 0) check(end_q[0] == exp_err, {req, " result code"}, end_q[0], exp_err);
    got_q.delete(); end_q.delete(); exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      summary();
    end
  end

  initial begin
    logic [15:0] c;
    void'($urandom(32'h5EED1));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(state == 3'd0 && !pay_vld && !pay_end, "R1 reset outputs", state, 0);
    check(cause == 3'd0, "R1 reset cause", cause, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 hunt ignores everything but the separator
    setup(0, 0, 0, 1, 1, 4'hF, 1);
    send(8'h55); send(8'hDB); send(8'hDC); strobe(1, 0); strobe(0, 1);
    check(state == 3'd0, "R2 stays in hunt", state, 0);
    expect_pkt("R2", 0, 0);

    // R5 latency, end timing
    setup(0, 0, 0, 0, 0, 4'hF, 1);
    send(8'hC0);
    check(state == 3'd2, "R11 payload state", state, 2);
    send(8'h5A);
    check(pay_vld && pay_byte == 8'h5A, "R5 one-cycle byte latency", pay_byte, 8'h5A);
    send(8'hC0);
    check(pay_end && pay_err == 3'd0, "R5 end one cycle after separator", pay_end, 1);
    send(8'h66); send(8'hC0);
    exp_q = '{8'h5A, 8'h66};
    expect_pkt("R5 separator reopens", 0, 2);
    setup(0, 0, 0, 0, 0, 4'hF, 1);
    send(8'hC0); send(8'hC0); send(8'hC0);
    expect_pkt("R5 empty packets silent", 0, 0);

    // R3 escape mapping
    setup(0, 0, 0, 0, 0, 4'hF, 1);
    send(8'hC0);
    send(8'hDB); send(8'hDC); send(8'hDB); send(8'hDD);
    send(8'hDB); send(8'hDE); send(8'hDB); send(8'hDF); send(8'h11); send(8'hC0);
    exp_q = '{8'hC0, 8'hDB, 8'h11, 8'h13, 8'h11};
    expect_pkt("R3 escape pairs", 0, 1);

    // R4 disabled mapping and unknown code
    setup(0, 0, 0, 0, 0, 4'b1011, 1);
    send(8'hC0); send(8'h41); send(8'hDB); send(8'hDE); send(8'h42);
    exp_q = '{8'h41};
    expect_pkt("R4 disabled escape", 1, 1);
    check(cause == 3'd1, "R11 cause after escape error", cause, 1);
    check(state == 3'd0, "R4 back to hunt", state, 0);
    setup(0, 0, 0, 0, 0, 4'hF, 1);
    check(cause == 3'd0, "R1 soft reset clears cause", cause, 0);
    send(8'hC0); send(8'h01); send(8'hDB); send(8'h00); send(8'h02); send(8'hC0);
    exp_q = '{8'h01};
    expect_pkt("R4 unknown escape code", 1, 1);

    // R6 count end, early separator, zero count
    setup(1, 0, 0, 0, 0, 4'hF, 5);
    send(8'hC0); send(8'h01); send(8'h02); send(8'hC0);
    exp_q = '{8'h01, 8'h02};
    expect_pkt("R6 early separator", 3, 1);
    setup(1, 0, 0, 0, 0, 4'hF, 0);
    send(8'hC0); send(8'h77); send(8'h78);
    exp_q = '{8'h77};
    expect_pkt("R6 zero count acts as one", 0, 1);

    // R7 header states and zero length
    setup(1, 1, 0, 0, 0, 4'hF, 9);
    send(8'hC0);
    check(state == 3'd1, "R11 header state", state, 1);
    send(8'h00); send(8'h00);
    exp_q.delete();
    expect_pkt("R7 zero length header", 0, 1);

    // R10 trailer state, mismatch, short
    setup(1, 0, 1, 0, 0, 4'hF, 1);
    send(8'hC0); send(8'h55);
    check(state == 3'd3, "R11 trailer state", state, 3);
    exp_q = '{8'h55}; c = crc_of(exp_q);
    send(c[15:8]); send(c[7:0]);
    expect_pkt("R10 count mode trailer", 0, 1);
    setup(0, 0, 1, 0, 0, 4'hF, 1);
    exp_q = '{8'h10, 8'h20, 8'h30}; c = crc_of(exp_q) ^ 16'h0001;
    send(8'hC0); send(8'h10); send(8'h20); send(8'h30); send(c[15:8]); send(c[7:0]); send(8'hC0);
    expect_pkt("R10 crc mismatch", 2, 1);
    send(8'hC0); send(8'h77); send(8'hC0);
    expect_pkt("R10 short trailer", 3, 1);

    // R8 idle end on and off
    setup(0, 0, 0, 1, 0, 4'hF, 1);
    send(8'hC0); send(8'hA1); send(8'hA2); strobe(1, 0);
    check(state == 3'd0, "R8 idle returns to hunt", state, 0);
    exp_q = '{8'hA1, 8'hA2};
    expect_pkt("R8 idle end", 0, 1);
    setup(0, 0, 0, 0, 0, 4'hF, 1);
    send(8'hC0); send(8'hA1); strobe(1, 0); send(8'hA2); send(8'hC0);
    exp_q = '{8'hA1, 8'hA2};
    expect_pkt("R8 idle ignored when off", 0, 1);

    // R9 break end on and off
    setup(0, 0, 0, 0, 1, 4'hF, 1);
    send(8'hC0); send(8'hB1); strobe(0, 1);
    exp_q = '{8'hB1};
    expect_pkt("R9 break end", 0, 1);
    setup(0, 0, 0, 0, 0, 4'hF, 1);
    send(8'hC0); send(8'hB1); strobe(0, 1); send(8'hB2); send(8'hC0);
    exp_q = '{8'hB1, 8'hB2};
    expect_pkt("R9 break ignored when off", 0, 1);

    // R12 strobe with byte drops the byte
    setup(0, 0, 0, 1, 0, 4'hF, 1);
    send(8'hC0); send(8'h61); send(8'h62, 1'b1, 1'b0);
    exp_q = '{8'h61};
    expect_pkt("R12 byte dropped with idle", 0, 1);

    // R1 soft reset mid packet
    setup(0, 0, 0, 0, 0, 4'hF, 1);
    send(8'hC0); send(8'h41);
    soft_rst = 1'b1; send(8'h42);
    check(state == 3'd0 && !pay_vld, "R1 soft reset drops packet", state, 0);
    soft_rst = 1'b0;
    send(8'h43); send(8'hC0); send(8'h44); send(8'hC0);
    exp_q = '{8'h41, 8'h44};
    expect_pkt("R1 after soft reset", 0, 1);

    // random packets across modes (R3 R5 R6 R7 R10)
    for (int p = 0; p < 40; p++) begin
      logic [31:0] m;
      int n;
      logic [7:0] pl[$];
      logic [15:0] cc;
      m = $urandom;
      n = 1 + int'($urandom % 16);
      setup(m[0], m[1], m[2], 0, 0, {m[4], m[3], 2'b11}, m[1] ? LEN_W'(1 + $urandom % 50) : LEN_W'(n));
      pl.delete();
      for (int i = 0; i < n; i++) begin
        case ($urandom % 6)
          0: pl.push_back(8'hC0);
          1: pl.push_back(8'hDB);
          2: pl.push_back(8'h11);
          3: pl.push_back(8'h13);
          default: pl.push_back(8'($urandom));
        endcase
      end
      cc = crc_of(pl);
      send(8'hC0);
      if (m[1]) begin
        send_enc(8'(n), m[3], m[4]);
        send_enc(8'h00, m[3], m[4]);
      end
      foreach (pl[i]) begin
        send_enc(pl[i], m[3] && m[5 + i % 8], m[4] && m[13 + i % 8]);
        if ($urandom % 4 == 0) strobe(m[21], !m[21]);
      end
      if (m[2]) begin
        send_enc(cc[15:8], m[3], m[4]);
        send_enc(cc[7:0], m[3], m[4]);
      end
      if (!m[0]) send(8'hC0);
      exp_q = pl;
      expect_pkt(m[0] ? "R6 random count packet" : "R5 random separator packet", 0, 1);
    end

    done = 1'b1;
    summary();
  end
endmodule